// File: doc/BRIEF.md
# Snooze Input Gating Controller

This block controls entry into and exit from a data-retaining standby state of a synchronous memory front end. A sleep request arrives as an asynchronous, active-high level. The block passes it through a two-flop synchroniser and then checks that the synchronised level has held for a fixed number of clock cycles. Only then does it enter snooze. While in snooze it replaces every synchronous control input with an idle pattern, so the device looks deselected. It also raises an output-disable flag, which the pad logic uses to tri-state the data outputs.

Exit works the same way in the other direction. The synchronised request must stay low for the exit dwell before input sampling resumes. A request that changes level part way through a dwell count restarts that count. A read or write in progress at entry is simply cut off: from the first snooze cycle the gated controls show no operation. The storage array lies outside this block, so its contents are untouched by anything the block does.

Top module: `snooze_gate_ctrl`

## Requirements
- R1: After reset is released, snooze and out_disable are low, and ctl_out equals ctl_in.
- R2: While snooze is low, ctl_out equals ctl_in in the same cycle, bit for bit.
- R3: Take the first rising edge that samples sleep_req high as edge 1, with sleep_req held high from then on. Snooze stays low through edge 3 and goes high just after edge 4 (two synchroniser stages plus ENTER_CYC = 2 dwell cycles).
- R4: While snooze is high, ctl_out equals IDLE_VALUE whatever ctl_in does. The default is all ones, meaning every active-low control is deasserted. The first snooze cycle already shows IDLE_VALUE, even if an operation was in progress.
- R5: Take the first rising edge that samples sleep_req low during snooze as edge 1, with sleep_req held low from then on. Snooze stays high through edge 3 and goes low just after edge 4 (two synchroniser stages plus EXIT_CYC = 2 dwell cycles).
- R6: A high level of sleep_req sampled on fewer than ENTER_CYC consecutive edges never raises snooze. A later high run restarts the entry count from zero.
- R7: A low level of sleep_req sampled on fewer than EXIT_CYC consecutive edges during snooze never lowers snooze. A later low run restarts the exit count from zero.
- R8: out_disable equals snooze in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Asynchronous active-high standby request |
| ctl_in | input | CTL_W | Raw synchronous control inputs |
| ctl_out | output | CTL_W | Gated control inputs for the core |
| snooze | output | 1 | High while the block is in standby |
| out_disable | output | 1 | High when the data outputs must be tri-stated |

## Verification
The bench measures the exact entry and exit latencies edge by edge. A design that counted the synchroniser delay twice, or dropped it, would switch one or more cycles away from edge 4. Single-cycle request pulses, in both directions, test the restart rule: a design that kept a partial count would switch on a later short pulse that should have had no effect. A random mix of request run lengths and control traffic checks gating on every cycle. It would expose controls that leak through during the first or last snooze cycle, as well as an idle pattern that is wrong in any single bit.

// File: rtl/snz_pkg.sv
package snz_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ENTER  = 2'd1,
    ST_ASLEEP = 2'd2,
    ST_EXIT   = 2'd3
  } snz_state_e;

  // true on the awake side of the state space (inputs pass through)
  function automatic logic snz_is_awake(snz_state_e s);
    return (s == ST_AWAKE) || (s == ST_ENTER);
  endfunction

  // total edges from first sample to the switch of the snooze flag
  function automatic int snz_latency(int sync_stages, int dwell);
    return sync_stages + dwell;
  endfunction

  function automatic snz_state_e snz_next(snz_state_e s, logic req,
                                          logic ent_done, logic ex_done);
    snz_state_e n;
    n = s;
    case (s)
      ST_AWAKE:  if (req)  n = ent_done ? ST_ASLEEP : ST_ENTER;
      ST_ENTER:  if (!req) n = ST_AWAKE;
                 else if (ent_done) n = ST_ASLEEP;
      ST_ASLEEP: if (!req) n = ex_done ? ST_AWAKE : ST_EXIT;
      ST_EXIT:   if (req)  n = ST_ASLEEP;
                 else if (ex_done) n = ST_AWAKE;
      default:   n = ST_AWAKE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/snz_dwell_ctr.sv
module snz_dwell_ctr #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || done) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/snz_gate.sv
module snz_gate #(
  parameter int             CTL_W      = 10,
  parameter logic [CTL_W-1:0] IDLE_VALUE = '1
) (
  input  logic             pass,
  input  logic [CTL_W-1:0] d,
  output logic [CTL_W-1:0] q
);
  generate
    for (genvar i = 0; i < CTL_W; i++) begin : g_bit
      assign q[i] = pass ? d[i] : IDLE_VALUE[i];
    end
  endgenerate
endmodule

// File: rtl/snooze_gate_ctrl.sv
module snooze_gate_ctrl
  import snz_pkg::*;
#(
  parameter int               CTL_W       = 10,
  parameter int               SYNC_STAGES = 2,
  parameter int               ENTER_CYC   = 2,
  parameter int               EXIT_CYC    = 2,
  parameter logic [CTL_W-1:0] IDLE_VALUE  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [CTL_W-1:0] ctl_in,
  output logic [CTL_W-1:0] ctl_out,
  output logic             snooze,
  output logic             out_disable
);
  // named internal events, used by the bound checker
  logic       req_sync;
  logic       enter_run, exit_run;
  logic       enter_done, exit_done;
  snz_state_e state, state_nxt;
  logic       awake_side;

  snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sleep_req), .q(req_sync)
  );

  assign awake_side = snz_is_awake(state);
  assign enter_run  = awake_side && req_sync;
  assign exit_run   = !awake_side && !req_sync;

  snz_dwell_ctr #(.LIMIT(ENTER_CYC)) u_enter_ctr (
    .clk(clk), .rst_n(rst_n), .run(enter_run), .done(enter_done)
  );

  snz_dwell_ctr #(.LIMIT(EXIT_CYC)) u_exit_ctr (
    .clk(clk), .rst_n(rst_n), .run(exit_run), .done(exit_done)
  );

  assign state_nxt = snz_next(state, req_sync, enter_done, exit_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_AWAKE;
    else        state <= state_nxt;
  end

  assign snooze      = !awake_side;
  assign out_disable = !awake_side;

  snz_gate #(.CTL_W(CTL_W), .IDLE_VALUE(IDLE_VALUE)) u_gate (
    .pass(awake_side), .d(ctl_in), .q(ctl_out)
  );
endmodule

// File: rtl/snooze_gate_ctrl_chk.sv
module snooze_gate_ctrl_chk
  import snz_pkg::*;
#(
  parameter int               CTL_W      = 10,
  parameter logic [CTL_W-1:0] IDLE_VALUE = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CTL_W-1:0] ctl_in,
  input logic [CTL_W-1:0] ctl_out,
  input logic             snooze,
  input logic             out_disable,
  input logic             req_sync,
  input logic             enter_done,
  input logic             exit_done,
  input snz_state_e       state
);
  a_r2_pass_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !snooze |-> ctl_out == ctl_in);

  a_r4_idle_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> ctl_out == IDLE_VALUE);

  a_r3_no_early_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !enter_done) |=> !snooze);

  a_r5_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (snooze && !exit_done) |=> snooze);

  a_r6_entry_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTER && !req_sync) |=> state == ST_AWAKE);

  a_r7_exit_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXIT && req_sync) |=> state == ST_ASLEEP);

  a_r8_disable_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable == snooze);
endmodule

bind snooze_gate_ctrl snooze_gate_ctrl_chk #(
  .CTL_W(CTL_W), .IDLE_VALUE(IDLE_VALUE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .ctl_out(ctl_out),
  .snooze(snooze), .out_disable(out_disable), .req_sync(req_sync),
  .enter_done(enter_done), .exit_done(exit_done), .state(state)
);

// File: tb/tb_snooze_gate_ctrl.sv
`timescale 1ns/1ps
module tb_snooze_gate_ctrl;
  localparam int CTL_W = 10;
  localparam int SYNC  = 2;
  localparam int DWELL = 2;
  localparam int LAT   = SYNC + DWELL;
  localparam logic [CTL_W-1:0] IDLE = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic [CTL_W-1:0] ctl_in = '0;
  logic [CTL_W-1:0] ctl_out;
  logic snooze, out_disable;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_on = 0;

  snooze_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ctl_in(ctl_in),
    .ctl_out(ctl_out), .snooze(snooze), .out_disable(out_disable)
  );

  always #10 clk = ~clk;

  // reference model: samples seen after the synchroniser delay,
  // dwell counted as a run of equal samples opposite to the current mode
  logic [SYNC-1:0] hist = '0;
  bit exp_sleep = 0;
  int streak = 0;

  function automatic logic [CTL_W-1:0] exp_ctl(bit asleep, logic [CTL_W-1:0] raw);
    return asleep ? IDLE : raw;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '0; exp_sleep = 0; streak = 0;
    end else begin
      logic seen;
      seen = hist[SYNC-1];
      hist = {hist[SYNC-2:0], sleep_req};
      if (seen != exp_sleep) begin
        streak++;
        if (streak == DWELL) begin exp_sleep = ~exp_sleep; streak = 0; end
      end else streak = 0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    chk("R8", 32'(out_disable), 32'(snooze));
    chk(exp_sleep ? "R4" : "R2", 32'(ctl_out), 32'(exp_ctl(exp_sleep, ctl_in)));
    chk(exp_sleep ? "R3" : "R5", 32'(snooze), 32'(exp_sleep));
  end

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5A0C;
    void'($urandom(seed));
    edges(3);
    rst_n = 1'b1;
    edges(1);
    // R1 reset state
    ctl_in = 10'h2A5;
    #1;
    chk("R1", 32'(snooze), 0);
    chk("R1", 32'(out_disable), 0);
    chk("R1", 32'(ctl_out), 32'(10'h2A5));
    model_on = 1;

    // R3 exact entry latency
    sleep_req = 1'b1;
    for (int e = 1; e <= LAT; e++) begin
      edges(1);
      chk("R3", 32'(snooze), (e >= LAT) ? 1 : 0);
    end
    // R4 controls masked while asleep, even with traffic
    ctl_in = 10'h000;
    #1 chk("R4", 32'(ctl_out), 32'(IDLE));
    ctl_in = 10'h155;
    #1 chk("R4", 32'(ctl_out), 32'(IDLE));

    // R7 single low pulse while asleep: stays asleep
    edges(1);
    sleep_req = 1'b0;
    edges(1);
    sleep_req = 1'b1;
    edges(6);
    chk("R7", 32'(snooze), 1);

    // R5 exact exit latency
    sleep_req = 1'b0;
    for (int e = 1; e <= LAT; e++) begin
      edges(1);
      chk("R5", 32'(snooze), (e >= LAT) ? 0 : 1);
    end
    ctl_in = 10'h0F0;
    #1 chk("R2", 32'(ctl_out), 32'(10'h0F0));

    // R6 single high pulses never enter, count restarts each time
    for (int p = 0; p < 3; p++) begin
      sleep_req = 1'b1;
      edges(1);
      sleep_req = 1'b0;
      edges(2);
    end
    edges(4);
    chk("R6", 32'(snooze), 0);

    // random runs of request levels with random control traffic
    for (int r = 0; r < 600; r++) begin
      sleep_req = $urandom_range(0, 1);
      for (int c = 0; c < int'($urandom_range(1, 6)); c++) begin
        ctl_in = CTL_W'($urandom);
        edges(1);
      end
    end

    sleep_req = 1'b0;
    edges(8);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule